// File: doc/BRIEF.md
# Hold-Arbitrated Shared Memory Bridge

This bridge gives a host processor on an asynchronous, strobe-and-acknowledge system bus access to the external program and data memory of a signal processor, without a dual-port RAM. A host cycle that falls inside a fixed address window does not touch the memory straight away. The bridge first asks the signal processor to give up its bus by pulling an active-low hold request. The host cycle is kept waiting, with its acknowledge held inactive, until the processor answers with its active-low hold-acknowledge.

Once the processor has released its pins, a small state machine in the bridge drives the memory bus itself for exactly one transfer. The transfer has a fixed, deliberately generous shape: an address setup phase, a strobe phase and a recovery phase, each a parameterised number of clock cycles. One host address bit chooses between the program-space select and the data-space select. For reads, the word is captured into a holding register during the strobe, so the memory bus can be let go before the host collects it. The acknowledge to the host is raised only when the transfer is completely over.

When the host removes its data strobe, the bridge drops the acknowledge and the hold request. It then waits for the processor to take its bus back before it accepts another cycle. Host cycles outside the window are ignored.

Top module: `shb_bridge`

## Requirements
- R1: A host cycle (host_as_n and host_ds_n both low) whose upper address bits, above bit MADDR_W, equal WIN_BASE pulls hold_n low on the clock edge after the bridge samples it, provided the bridge is idle.
- R2: host_dtack_n stays high while holda_n is high and until the whole transfer is finished. With holda_n arriving L cycles after hold_n, the host sees host_dtack_n low exactly 2+L+SETUP_CYC+STROBE_CYC+RECOV_CYC cycles after the cycle is first sampled.
- R3: mem_drive, the enable of the bridge's memory-bus drivers, is high only while holda_n is low.
- R4: A transfer drives the address with both strobes inactive for SETUP_CYC cycles. It then holds one strobe active for STROBE_CYC cycles, then keeps the address driven with strobes inactive for RECOV_CYC cycles. mem_addr does not change while a strobe is active.
- R5: For a host read (host_rd_wr = 1), the word on mem_rdata in the last strobe cycle appears on host_rdata and stays there while host_dtack_n is low, even though the memory bus is no longer driven.
- R6: For a host write (host_rd_wr = 0), mem_wr_n is the active strobe and mem_wdata carries the host write word, which is stored at mem_addr = host_addr[MADDR_W-1:0].
- R7: Host address bit MADDR_W = 0 selects program space (mem_prog_sel_n low); 1 selects data space (mem_data_sel_n low). Exactly one select is low whenever mem_drive is high.
- R8: Out of reset, hold_n and host_dtack_n are high and mem_drive is low. After the acknowledge, host_ds_n going high returns host_dtack_n and hold_n high on the next edge. hold_n is not pulled low again until holda_n has been seen high.
- R9: A host cycle outside the window leaves hold_n and host_dtack_n high and mem_drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_as_n | input | 1 | Host address strobe, active low |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_rd_wr | input | 1 | Host direction, 1 = read, 0 = write |
| host_addr | input | HADDR_W | Host byte/word address |
| host_wdata | input | DATA_W | Host write word |
| host_rdata | output | DATA_W | Buffered read word |
| host_dtack_n | output | 1 | Transfer acknowledge to host, active low |
| hold_n | output | 1 | Bus request to the signal processor, active low |
| holda_n | input | 1 | Bus release acknowledge from the processor, active low |
| mem_drive | output | 1 | Enable of the bridge's memory-bus drivers |
| mem_addr | output | MADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word |
| mem_prog_sel_n | output | 1 | Program-space select, active low |
| mem_data_sel_n | output | 1 | Data-space select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the bridge with an 8-bit host address, a 4-bit memory address, 8-bit data, window tag 3'b101, and setup, strobe and recovery lengths of 2, 3 and 1 cycles. With these values every one of the 256 host addresses can be swept. That covers all 224 addresses outside the window and all 32 window words in both memory spaces. The window words are written and read back under hold-acknowledge latencies of 0 to 3 cycles, so each latency gives its own arithmetic acknowledge time and phase counts. A slow release followed by an immediate new cycle shows that the bridge will not request the bus again before it has been handed back.

// File: rtl/shb_pkg.sv
package shb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_REQ    = 3'd1,
      ST_SETUP  = 3'd2,
      ST_STROBE = 3'd3,
      ST_RECOV  = 3'd4,
      ST_ACK    = 3'd5,
      ST_REL    = 3'd6
   } shb_state_e;

   function automatic int unsigned shb_max3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/shb_window_decode.sv
module shb_window_decode #(
   parameter int unsigned HADDR_W  = 16,
   parameter int unsigned MADDR_W  = 12,
   parameter int unsigned WIN_BASE = 7
) (
   input  logic [HADDR_W-1:0] host_addr,
   output logic               hit,
   output logic               data_space,
   output logic [MADDR_W-1:0] local_addr
);
   localparam int unsigned TAG_W = HADDR_W - MADDR_W - 1;

   initial begin : p_param_chk
      assert (MADDR_W >= 1) else $error("MADDR_W must be at least 1");
      assert (HADDR_W >= MADDR_W + 1) else $error("HADDR_W too small for window");
   end

   assign local_addr = host_addr[MADDR_W-1:0];
   assign data_space = host_addr[MADDR_W];

   generate
      if (TAG_W > 0) begin : g_tag
         localparam logic [TAG_W-1:0] TAG = TAG_W'(WIN_BASE);
         assign hit = (host_addr[HADDR_W-1 -: TAG_W] == TAG);
      end else begin : g_full
         assign hit = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/shb_xfer_fsm.sv
module shb_xfer_fsm
   import shb_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned STROBE_CYC = 2,
   parameter int unsigned RECOV_CYC  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic holda_n,
   input  logic host_ds_n,
   output logic idle,
   output logic load,
   output logic hold_n,
   output logic drive,
   output logic strobe,
   output logic capture,
   output logic ack
);
   localparam int unsigned CNT_MAX = shb_max3(SETUP_CYC, STROBE_CYC, RECOV_CYC);
   localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] RECOV_LD  = CNT_W'(RECOV_CYC - 1);

   initial begin : p_param_chk
      assert (SETUP_CYC >= 1)  else $error("SETUP_CYC must be at least 1");
      assert (STROBE_CYC >= 1) else $error("STROBE_CYC must be at least 1");
      assert (RECOV_CYC >= 1)  else $error("RECOV_CYC must be at least 1");
   end

   shb_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             cnt_done;

   assign cnt_done = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req) state <= ST_REQ;
            end
            ST_REQ: begin
               if (!holda_n) begin
                  state <= ST_SETUP;
                  cnt   <= SETUP_LD;
               end
            end
            ST_SETUP: begin
               if (cnt_done) begin
                  state <= ST_STROBE;
                  cnt   <= STROBE_LD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STROBE: begin
               if (cnt_done) begin
                  state <= ST_RECOV;
                  cnt   <= RECOV_LD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_RECOV: begin
               if (cnt_done) state <= ST_ACK;
               else          cnt   <= cnt - 1'b1;
            end
            ST_ACK: begin
               if (host_ds_n) state <= ST_REL;
            end
            ST_REL: begin
               if (holda_n) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle    = (state == ST_IDLE);
   assign load    = idle && req;
   assign hold_n  = !(state inside {ST_REQ, ST_SETUP, ST_STROBE, ST_RECOV, ST_ACK});
   assign drive   = (state inside {ST_SETUP, ST_STROBE, ST_RECOV});
   assign strobe  = (state == ST_STROBE);
   assign capture = strobe && cnt_done;
   assign ack     = (state == ST_ACK);

   // R2: the acknowledge phase is entered only from the recovery phase
   a_r2_ack_after_recover: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(state) == ST_RECOV);

   // R8: once released, the request stays off until the bus comes back
   a_r8_release_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL && !holda_n) |=> hold_n);

endmodule

// File: rtl/shb_data_path.sv
module shb_data_path #(
   parameter int unsigned MADDR_W     = 12,
   parameter int unsigned DATA_W      = 16,
   parameter bit          CAPTURE_REQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               capture,
   input  logic               ack,
   input  logic [MADDR_W-1:0] in_addr,
   input  logic               in_space,
   input  logic               in_rd,
   input  logic [DATA_W-1:0]  in_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [MADDR_W-1:0] addr_q,
   output logic               space_q,
   output logic               rd_q,
   output logic [DATA_W-1:0]  wdata_q,
   output logic [DATA_W-1:0]  rdata_q
);
   initial begin : p_param_chk
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   generate
      if (CAPTURE_REQ) begin : g_reg_req
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q  <= '0;
               space_q <= 1'b0;
               rd_q    <= 1'b1;
               wdata_q <= '0;
            end else if (load) begin
               addr_q  <= in_addr;
               space_q <= in_space;
               rd_q    <= in_rd;
               wdata_q <= in_wdata;
            end
         end
      end else begin : g_pass_req
         assign addr_q  = in_addr;
         assign space_q = in_space;
         assign rd_q    = in_rd;
         assign wdata_q = in_wdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                rdata_q <= '0;
      else if (capture && rd_q)  rdata_q <= mem_rdata;
   end

   // R5: the buffered word does not move while the host is acknowledged
   a_r5_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(ack)) |-> $stable(rdata_q));

endmodule

// File: rtl/shb_bridge.sv
module shb_bridge #(
   parameter int unsigned HADDR_W     = 16,
   parameter int unsigned MADDR_W     = 12,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned WIN_BASE    = 7,
   parameter int unsigned SETUP_CYC   = 1,
   parameter int unsigned STROBE_CYC  = 2,
   parameter int unsigned RECOV_CYC   = 1,
   parameter bit          CAPTURE_REQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_as_n,
   input  logic               host_ds_n,
   input  logic               host_rd_wr,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_dtack_n,
   output logic               hold_n,
   input  logic               holda_n,
   output logic               mem_drive,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               mem_prog_sel_n,
   output logic               mem_data_sel_n,
   output logic               mem_rd_n,
   output logic               mem_wr_n
);
   logic               hit, space_dec;
   logic [MADDR_W-1:0] addr_dec;
   logic               req, idle, load, drive, strobe, capture, ack;
   logic [MADDR_W-1:0] addr_q;
   logic               space_q, rd_q;
   logic [DATA_W-1:0]  wdata_q, rdata_q;

   shb_window_decode #(
      .HADDR_W (HADDR_W),
      .MADDR_W (MADDR_W),
      .WIN_BASE(WIN_BASE)
   ) u_decode (
      .host_addr (host_addr),
      .hit       (hit),
      .data_space(space_dec),
      .local_addr(addr_dec)
   );

   assign req = !host_as_n && !host_ds_n && hit;

   shb_xfer_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .STROBE_CYC(STROBE_CYC),
      .RECOV_CYC (RECOV_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .holda_n  (holda_n),
      .host_ds_n(host_ds_n),
      .idle     (idle),
      .load     (load),
      .hold_n   (hold_n),
      .drive    (drive),
      .strobe   (strobe),
      .capture  (capture),
      .ack      (ack)
   );

   shb_data_path #(
      .MADDR_W    (MADDR_W),
      .DATA_W     (DATA_W),
      .CAPTURE_REQ(CAPTURE_REQ)
   ) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .capture  (capture),
      .ack      (ack),
      .in_addr  (addr_dec),
      .in_space (space_dec),
      .in_rd    (host_rd_wr),
      .in_wdata (host_wdata),
      .mem_rdata(mem_rdata),
      .addr_q   (addr_q),
      .space_q  (space_q),
      .rd_q     (rd_q),
      .wdata_q  (wdata_q),
      .rdata_q  (rdata_q)
   );

   assign mem_drive      = drive;
   assign mem_addr       = drive ? addr_q : '0;
   assign mem_wdata      = (drive && !rd_q) ? wdata_q : '0;
   assign mem_prog_sel_n = !(drive && !space_q);
   assign mem_data_sel_n = !(drive && space_q);
   assign mem_rd_n       = !(strobe && rd_q);
   assign mem_wr_n       = !(strobe && !rd_q);
   assign host_rdata     = rdata_q;
   assign host_dtack_n   = !ack;

   // R3: drivers enabled only while the processor has released its bus
   a_r3_drive_needs_holda: assert property (@(posedge clk) disable iff (!rst_n)
      mem_drive |-> !holda_n);

   // R7: exactly one space select while the bus is driven
   a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      mem_drive |-> ($countones({mem_prog_sel_n, mem_data_sel_n}) == 1));

   // R4: address steady through an active strobe
   a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ((!mem_rd_n || !mem_wr_n) && $past(mem_drive)) |-> $stable(mem_addr));

   // R8: a new request only after the processor was seen owning its bus
   a_r8_request_after_return: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_n) |-> $past(holda_n));

   // R9: an idle bridge ignores cycles outside the window
   a_r9_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !host_as_n && !host_ds_n && !hit) |=> hold_n);

   // R2: no acknowledge without the processor's release
   a_r2_ack_needs_holda: assert property (@(posedge clk) disable iff (!rst_n)
      !host_dtack_n |-> !holda_n);

endmodule

// File: tb/shb_bridge_tb.sv
`timescale 1ns/1ps
module shb_bridge_tb;
   localparam int HW = 8, MW = 4, DW = 8;
   localparam int TS = 2, TT = 3, TR = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_as_n = 1'b1, host_ds_n = 1'b1, host_rd_wr = 1'b1;
   logic [HW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic host_dtack_n, hold_n, holda_n, mem_drive;
   logic [MW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic mem_prog_sel_n, mem_data_sel_n, mem_rd_n, mem_wr_n;

   always #2 clk = ~clk;

   shb_bridge #(
      .HADDR_W(HW), .MADDR_W(MW), .DATA_W(DW), .WIN_BASE(5),
      .SETUP_CYC(TS), .STROBE_CYC(TT), .RECOV_CYC(TR), .CAPTURE_REQ(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_as_n(host_as_n), .host_ds_n(host_ds_n), .host_rd_wr(host_rd_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_dtack_n(host_dtack_n), .hold_n(hold_n), .holda_n(holda_n),
      .mem_drive(mem_drive), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_prog_sel_n(mem_prog_sel_n),
      .mem_data_sel_n(mem_data_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
   );

   // processor model: releases its bus 'lat' cycles after the request
   int lat = 0;
   logic [3:0] hist;
   always_ff @(posedge clk) begin
      if (!rst_n) hist <= 4'hF;
      else        hist <= {hist[2:0], hold_n};
   end
   assign holda_n = (lat == 0) ? hold_n : hist[lat-1];

   // memory model
   logic [DW-1:0] prog_mem [16];
   logic [DW-1:0] data_mem [16];
   assign mem_rdata = (mem_drive && !mem_rd_n) ?
                      (!mem_prog_sel_n ? prog_mem[mem_addr] : data_mem[mem_addr]) : 8'hEE;
   always @(posedge clk) begin
      if (mem_drive && !mem_wr_n) begin
         if (!mem_prog_sel_n)      prog_mem[mem_addr] <= mem_wdata;
         else if (!mem_data_sel_n) data_mem[mem_addr] <= mem_wdata;
      end
   end

   int total = 0, bad = 0;
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // bus monitor
   int n_setup, n_strobe, n_recov, ph;
   int v_bus = 0, v_hold = 0, v_ack = 0, v_sel = 0;
   logic [MW-1:0] st_addr;
   logic st_data;
   logic prev_hold = 1'b1, prev_holda = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_drive) begin
            if (!mem_rd_n || !mem_wr_n) begin
               n_strobe++; ph = 1; st_addr = mem_addr; st_data = !mem_data_sel_n;
            end else if (ph == 0) n_setup++;
            else n_recov++;
            if ((mem_prog_sel_n ^ mem_data_sel_n) == 1'b0) v_sel++;
         end
         if (mem_drive && holda_n) v_bus++;
         if (!host_dtack_n && holda_n) v_ack++;
         if (prev_hold && !hold_n && !prev_holda) v_hold++;
      end
      prev_hold  = hold_n;
      prev_holda = holda_n;
   end

   bit t_ack;
   logic [DW-1:0] t_rd;
   int t_n;

   task automatic host_cycle(input logic [HW-1:0] a, input bit rd,
                             input logic [DW-1:0] wd, input bit gap);
      @(negedge clk);
      n_setup = 0; n_strobe = 0; n_recov = 0; ph = 0;
      host_addr = a; host_rd_wr = rd; host_wdata = wd;
      host_as_n = 1'b0; host_ds_n = 1'b0;
      t_n = 0;
      do begin
         @(negedge clk);
         t_n++;
      end while (host_dtack_n && t_n < 60);
      t_ack = !host_dtack_n;
      t_rd  = host_rdata;
      host_as_n = 1'b1; host_ds_n = 1'b1;
      @(negedge clk);
      chk(hold_n && host_dtack_n, "R8 release after strobe", {hold_n, host_dtack_n}, 3);
      if (gap) begin
         for (int k = 0; k < 20 && !holda_n; k++) @(negedge clk);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin prog_mem[i] = '0; data_mem[i] = '0; end
      repeat (3) @(negedge clk);
      chk(hold_n && host_dtack_n && !mem_drive, "R8 reset state",
          {hold_n, host_dtack_n, mem_drive}, 6);
      rst_n = 1'b1;
      @(negedge clk);

      for (int l = 0; l < 4; l++) begin
         lat = l;
         for (int a = 0; a < 32; a++) begin
            logic [DW-1:0] v;
            v = DW'(a * 29 + l * 53 + 7);
            host_cycle({3'b101, 5'(a)}, 1'b0, v, 1'b1);
            chk(t_ack && t_n == 2 + l + TS + TT + TR, "R2 write ack time", t_n, 2 + l + TS + TT + TR);
            chk(n_setup == TS && n_strobe == TT && n_recov == TR, "R4 phase lengths",
                n_setup * 256 + n_strobe * 16 + n_recov, TS * 256 + TT * 16 + TR);
            chk(st_addr == 4'(a) && st_data == a[4], "R7 space and address",
                {st_data, st_addr}, a);
            if (a[4]) chk(data_mem[a[3:0]] == v, "R6 data-space write", data_mem[a[3:0]], v);
            else      chk(prog_mem[a[3:0]] == v, "R6 program-space write", prog_mem[a[3:0]], v);
         end
         for (int a = 0; a < 32; a++) begin
            logic [DW-1:0] v;
            v = DW'(a * 29 + l * 53 + 7);
            host_cycle({3'b101, 5'(a)}, 1'b1, 8'h00, 1'b1);
            chk(t_ack && t_n == 2 + l + TS + TT + TR, "R2 read ack time", t_n, 2 + l + TS + TT + TR);
            chk(t_rd == v, "R5 buffered read word", t_rd, v);
            chk(n_strobe == TT, "R4 read strobe length", n_strobe, TT);
         end
      end

      // R9: every address outside the window
      lat = 1;
      for (int h = 0; h < 256; h++) begin
         if (h[7:5] != 3'b101) begin
            bit quiet;
            quiet = 1'b1;
            @(negedge clk);
            host_addr = 8'(h); host_rd_wr = h[0]; host_wdata = 8'h5A;
            host_as_n = 1'b0; host_ds_n = 1'b0;
            for (int k = 0; k < 12; k++) begin
               @(negedge clk);
               if (!hold_n || !host_dtack_n || mem_drive) quiet = 1'b0;
            end
            chk(quiet, "R9 miss ignored", h, 0);
            host_as_n = 1'b1; host_ds_n = 1'b1;
            @(negedge clk);
         end
      end
      chk(prog_mem[4'h3] == 8'(3 * 29 + 3 * 53 + 7), "R9 memory untouched by misses",
          prog_mem[4'h3], 8'(3 * 29 + 3 * 53 + 7));

      // R1 and R8: slow bus return followed at once by a new cycle
      lat = 3;
      host_cycle(8'hA2, 1'b0, 8'hC3, 1'b0);
      chk(t_ack, "R1 window hit acknowledged", t_ack, 1);
      host_cycle(8'hA2, 1'b1, 8'h00, 1'b1);
      chk(t_ack && t_rd == 8'hC3, "R8 back-to-back read", t_rd, 8'hC3);
      @(negedge clk);
      host_addr = 8'hB7; host_rd_wr = 1'b1; host_as_n = 1'b0; host_ds_n = 1'b0;
      @(negedge clk);
      chk(!hold_n, "R1 hold request on hit", hold_n, 0);
      chk(host_dtack_n, "R2 wait state while holda high", host_dtack_n, 1);
      host_as_n = 1'b1; host_ds_n = 1'b1;
      repeat (12) @(negedge clk);
      host_as_n = 1'b0; host_ds_n = 1'b0;
      repeat (3) @(negedge clk);
      host_as_n = 1'b1; host_ds_n = 1'b1;
      repeat (8) @(negedge clk);

      chk(v_bus == 0, "R3 drive only with holda", v_bus, 0);
      chk(v_hold == 0, "R8 no request before bus return", v_hold, 0);
      chk(v_ack == 0, "R2 no ack without holda", v_ack, 0);
      chk(v_sel == 0, "R7 single select", v_sel, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule